// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between a set of interrupt sources and a small processor core. It gathers requests from several device lines, one non-maskable line and one software-raised line. It holds each request until the core takes it. It chooses a single request by fixed priority and offers it to the core as a trap address. The trap address is taken from a vector table that starts at a configurable base and uses a constant spacing between entries.

The offer to the core is a valid/ack handshake. `irq_valid` with `irq_vector` is the offer, and `ack` is the core's acceptance. A transfer happens in any cycle where both are high. While the core holds `ack` low, the pending request is not lost and the offer stays up. Only a mask write can withdraw it, and a more urgent source can replace it.

When a request is taken, the block sets the global mask by itself. Device requests that arrive later wait until the core signals the end of service on `ret`. At the same time a nesting pointer counts up on each entry and down on each return. The core uses this pointer to pick a register bank.

Top module: `prio_vec_intc`

## Requirements
- R1: Device line i is offered only while the global mask is 0 and mask bit i is 0. After reset the global mask is 0 and every per-device mask bit is 1. `gmask_we` loads `gmask_wd` into the global mask. `smask_we` loads `smask_wd`, and bit i of that word masks device i.
- R2: A pending non-maskable request is offered whatever the masks hold, and it wins over every other source.
- R3: Among offerable device requests, the lowest index wins. The software request has the lowest priority of all sources and ignores both kinds of mask.
- R4: An accept (`irq_valid && ack`) clears only the chosen source's pending flag and sets the global mask. Other device requests stay pending and are offered after `ret`.
- R5: `irq_vector` = VEC_BASE + slot*VEC_STEP. Slot 0 is the non-maskable source, slot 1+i is device i, and slot N_DEV+1 is the software source. With the defaults this gives 0x100, 0x104 to 0x110, and 0x114.
- R6: Each accept raises `bank_ptr` by one, and the pointer stays at MAX_DEPTH once it reaches it.
- R7: `ret` clears the global mask and lowers `bank_ptr` by one, and the pointer stays at 0 once it reaches it. When an accept and `ret` fall in the same cycle, the accept sets the mask and `bank_ptr` does not change. For the mask, an accept takes precedence over `ret`, and `ret` takes precedence over a software write.
- R8: A one-cycle pulse on any request line sets that source's pending flag, and the flag holds until that source is accepted. A pulse that arrives in the same cycle as the acceptance of its own source leaves the source pending. Masking a source never clears its pending flag.
- R9: `ack` while `irq_valid` is low changes nothing. While `irq_valid` is high and `ack` is low, `irq_valid` stays high unless a mask write happens.
- R10: After reset nothing is pending, `irq_valid` is 0 and `bank_ptr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_req | input | N_DEV | Device request lines; a high cycle sets pending |
| nmi_req | input | 1 | Non-maskable request |
| sw_req | input | 1 | Software-raised request |
| gmask_we | input | 1 | Global mask write strobe |
| gmask_wd | input | 1 | Global mask write value |
| smask_we | input | 1 | Per-device mask write strobe |
| smask_wd | input | N_DEV | Per-device mask write value |
| irq_valid | output | 1 | A request is offered |
| irq_vector | output | ADDR_W | Trap address of the offered request |
| ack | input | 1 | Core takes the offered request |
| ret | input | 1 | Core ends service of the current request |
| gmask | output | 1 | Current global mask |
| bank_ptr | output | PTR_W | Nesting level / register bank select |

## Verification
A pending flag that is lost or stuck appears at the ports one cycle after the next accept or request pulse. In that cycle the wrong slot turns up in `irq_vector`, or `irq_valid` fails to rise or fall. A wrong priority order or wrong mask decode shows up in the very cycle the pending set changes. The near-exhaustive sweep over every pattern of device requests and mask bits exposes it. Errors in the nesting pointer or the global mask become visible one cycle after an accept or `ret`, through `bank_ptr`, `gmask` and whether queued device requests are offered.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_NMI  = 2'd1,
    SRC_DEV  = 2'd2,
    SRC_SOFT = 2'd3
  } src_kind_e;
endpackage

// File: rtl/intc_pending.sv
module intc_pending #(
  parameter int N_SLOT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SLOT-1:0] set_i,
  input  logic [N_SLOT-1:0] clr_i,
  output logic [N_SLOT-1:0] pend_o
);
  logic [N_SLOT-1:0] pend_q;

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[s] <= 1'b0;
      else        pend_q[s] <= set_i[s] | (pend_q[s] & ~clr_i[s]);
    end

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[s] |=> pend_q[s]); // R8
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int N_DEV  = 4,
  parameter int N_SLOT = N_DEV + 2,
  parameter int SLOT_W = $clog2(N_SLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SLOT-1:0] pend_i,
  input  logic              gmask_i,
  input  logic [N_DEV-1:0]  smask_i,
  output logic              valid_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [N_SLOT-1:0] grant_o,
  output src_kind_e         kind_o
);
  logic [N_SLOT-1:0] elig;

  assign elig[0] = pend_i[0];
  for (genvar i = 0; i < N_DEV; i++) begin : g_dev
    assign elig[i+1] = pend_i[i+1] & ~gmask_i & ~smask_i[i];
  end
  assign elig[N_SLOT-1] = pend_i[N_SLOT-1];

  always_comb begin
    valid_o = 1'b0;
    slot_o  = '0;
    for (int s = N_SLOT - 1; s >= 0; s--) begin
      if (elig[s]) begin
        valid_o = 1'b1;
        slot_o  = SLOT_W'(s);
      end
    end
  end

  always_comb begin
    grant_o = '0;
    if (valid_o) grant_o[slot_o] = 1'b1;
  end

  always_comb begin
    if (!valid_o)                              kind_o = SRC_NONE;
    else if (slot_o == '0)                     kind_o = SRC_NMI;
    else if (slot_o == SLOT_W'(N_SLOT - 1))    kind_o = SRC_SOFT;
    else                                       kind_o = SRC_DEV;
  end

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && gmask_i) |-> (kind_o != SRC_DEV)); // R1
  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    pend_i[0] |-> (valid_o && kind_o == SRC_NMI)); // R2
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o)); // R3
endmodule

// File: rtl/intc_nest.sv
module intc_nest #(
  parameter int N_DEV     = 4,
  parameter int MAX_DEPTH = 3,
  parameter int PTR_W     = $clog2(MAX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             ret_i,
  input  logic             gmask_we_i,
  input  logic             gmask_wd_i,
  input  logic             smask_we_i,
  input  logic [N_DEV-1:0] smask_wd_i,
  output logic             gmask_o,
  output logic [N_DEV-1:0] smask_o,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(MAX_DEPTH);

  logic             gmask_q;
  logic [N_DEV-1:0] smask_q;
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gmask_q <= 1'b0;
    end else if (accept_i) begin
      gmask_q <= 1'b1;
    end else if (ret_i) begin
      gmask_q <= 1'b0;
    end else if (gmask_we_i) begin
      gmask_q <= gmask_wd_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          smask_q <= '1;
    else if (smask_we_i) smask_q <= smask_wd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (accept_i && !ret_i) begin
      if (ptr_q != PTR_MAX) ptr_q <= ptr_q + 1'b1;
    end else if (ret_i && !accept_i) begin
      if (ptr_q != '0) ptr_q <= ptr_q - 1'b1;
    end
  end

  assign gmask_o = gmask_q;
  assign smask_o = smask_q;
  assign ptr_o   = ptr_q;

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= PTR_MAX); // R6
  AST_ACCEPT_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> gmask_q); // R4
  AST_PTR_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && !ret_i && ptr_q != PTR_MAX) |=> ptr_q == $past(ptr_q) + 1'b1); // R6
  AST_PTR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !accept_i && ptr_q != '0) |=> ptr_q == $past(ptr_q) - 1'b1); // R7
  AST_RET_UNMASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !accept_i) |=> !gmask_q); // R7
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import intc_pkg::*;
#(
  parameter int N_DEV     = 4,
  parameter int ADDR_W    = 16,
  parameter int VEC_BASE  = 'h100,
  parameter int VEC_STEP  = 4,
  parameter int MAX_DEPTH = 3,
  parameter int PTR_W     = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_DEV-1:0]  dev_req,
  input  logic              nmi_req,
  input  logic              sw_req,
  input  logic              gmask_we,
  input  logic              gmask_wd,
  input  logic              smask_we,
  input  logic [N_DEV-1:0]  smask_wd,
  output logic              irq_valid,
  output logic [ADDR_W-1:0] irq_vector,
  input  logic              ack,
  input  logic              ret,
  output logic              gmask,
  output logic [PTR_W-1:0]  bank_ptr
);
  localparam int N_SLOT = N_DEV + 2;
  localparam int SLOT_W = $clog2(N_SLOT);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(VEC_BASE);
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(VEC_STEP);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(VEC_BASE + (N_SLOT - 1) * VEC_STEP);

  logic [N_SLOT-1:0] req_set, req_clr, pend;
  logic [N_SLOT-1:0] grant;
  logic [SLOT_W-1:0] slot;
  logic [N_DEV-1:0]  smask;
  logic              offer, accept;
  src_kind_e         kind;

  assign req_set = {sw_req, dev_req, nmi_req};
  assign accept  = offer & ack;
  assign req_clr = accept ? grant : '0;

  intc_pending #(.N_SLOT(N_SLOT)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .set_i(req_set), .clr_i(req_clr), .pend_o(pend)
  );

  intc_arbiter #(.N_DEV(N_DEV), .N_SLOT(N_SLOT), .SLOT_W(SLOT_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .pend_i(pend), .gmask_i(gmask), .smask_i(smask),
    .valid_o(offer), .slot_o(slot), .grant_o(grant), .kind_o(kind)
  );

  intc_nest #(.N_DEV(N_DEV), .MAX_DEPTH(MAX_DEPTH), .PTR_W(PTR_W)) u_nest (
    .clk(clk), .rst_n(rst_n),
    .accept_i(accept), .ret_i(ret),
    .gmask_we_i(gmask_we), .gmask_wd_i(gmask_wd),
    .smask_we_i(smask_we), .smask_wd_i(smask_wd),
    .gmask_o(gmask), .smask_o(smask), .ptr_o(bank_ptr)
  );

  assign irq_valid  = offer;
  assign irq_vector = BASE_A + ADDR_W'(slot) * STEP_A;

  AST_NMI_OFFERED: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> (irq_valid && irq_vector == BASE_A)); // R2
  AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector >= BASE_A && irq_vector <= LAST_A)); // R5
  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !ack && !gmask_we && !smask_we) |=> irq_valid); // R9
  AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_valid && ack && !ret && !gmask_we) |=> $stable(bank_ptr) && $stable(gmask)); // R9
endmodule

// File: tb/prio_vec_intc_bench.sv
module prio_vec_intc_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] dev_req = '0;
  logic nmi_req = 1'b0, sw_req = 1'b0;
  logic gmask_we = 1'b0, gmask_wd = 1'b0, smask_we = 1'b0;
  logic [3:0] smask_wd = '0;
  logic ack = 1'b0, ret = 1'b0;
  logic irq_valid, gmask;
  logic [15:0] irq_vector;
  logic [1:0] bank_ptr;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prio_vec_intc u_prio_vec_intc (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .nmi_req(nmi_req),
    .sw_req(sw_req), .gmask_we(gmask_we), .gmask_wd(gmask_wd),
    .smask_we(smask_we), .smask_wd(smask_wd), .irq_valid(irq_valid),
    .irq_vector(irq_vector), .ack(ack), .ret(ret), .gmask(gmask),
    .bank_ptr(bank_ptr)
  );

  function automatic logic [15:0] vexp(input int slot);
    return 16'(16'h100 + slot * 4);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic write_smask(input logic [3:0] m);
    smask_we = 1'b1; smask_wd = m; step(); smask_we = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R10 reset state
    chk("R10 valid", 32'(irq_valid), 0);
    chk("R10 ptr", 32'(bank_ptr), 0);
    chk("R1 gmask reset", 32'(gmask), 0);
    dev_req = 4'hF; step(); dev_req = '0;
    chk("R1 smask reset masks all", 32'(irq_valid), 0);

    // R1 R3 R5 sweep of request pattern x mask pattern
    for (int p = 0; p < 16; p++) begin
      for (int m = 0; m < 16; m++) begin
        int win;
        do_reset();
        write_smask(4'(m));
        dev_req = 4'(p); step(); dev_req = '0;
        win = -1;
        for (int i = 3; i >= 0; i--) if (p[i] && !m[i]) win = i;
        chk("R1 sweep valid", 32'(irq_valid), (win >= 0) ? 1 : 0);
        if (win >= 0) chk("R3 R5 sweep vector", 32'(irq_vector), 32'(vexp(win + 1)));
      end
    end

    // R1 R2 R3 global mask and source order
    do_reset();
    write_smask(4'h0);
    gmask_we = 1'b1; gmask_wd = 1'b1; step(); gmask_we = 1'b0;
    dev_req = 4'b1000; step(); dev_req = '0;
    chk("R1 gmask blocks device", 32'(irq_valid), 0);
    sw_req = 1'b1; step(); sw_req = 1'b0;
    chk("R3 soft ignores mask", 32'(irq_valid), 1);
    chk("R3 soft vector", 32'(irq_vector), 32'(vexp(5)));
    nmi_req = 1'b1; step(); nmi_req = 1'b0;
    chk("R2 nmi vector", 32'(irq_vector), 32'(vexp(0)));
    ack = 1'b1; step(); ack = 1'b0;
    chk("R2 after nmi taken soft offered", 32'(irq_vector), 32'(vexp(5)));
    ack = 1'b1; step(); ack = 1'b0;
    chk("R1 device still masked", 32'(irq_valid), 0);
    chk("R6 ptr two", 32'(bank_ptr), 2);

    // R6 R7 nesting and saturation
    do_reset();
    for (int k = 1; k <= 4; k++) begin
      nmi_req = 1'b1; step(); nmi_req = 1'b0;
      ack = 1'b1; step(); ack = 1'b0;
      chk("R6 ptr up", 32'(bank_ptr), (k > 3) ? 3 : k);
    end
    chk("R4 mask set", 32'(gmask), 1);
    for (int k = 1; k <= 4; k++) begin
      ret = 1'b1; step(); ret = 1'b0;
      chk("R7 ptr down", 32'(bank_ptr), (k > 3) ? 0 : 3 - k);
      chk("R7 mask cleared", 32'(gmask), 0);
    end

    // R4 queueing, R7 simultaneous ack and ret
    do_reset();
    write_smask(4'h0);
    dev_req = 4'b0110; step(); dev_req = '0;
    chk("R3 dev1 first", 32'(irq_vector), 32'(vexp(2)));
    ack = 1'b1; step(); ack = 1'b0;
    chk("R4 dev2 waits", 32'(irq_valid), 0);
    chk("R4 gmask set", 32'(gmask), 1);
    chk("R6 ptr one", 32'(bank_ptr), 1);
    ret = 1'b1; step(); ret = 1'b0;
    chk("R4 dev2 offered", 32'(irq_vector), 32'(vexp(3)));
    chk("R7 ptr zero", 32'(bank_ptr), 0);
    ack = 1'b1; ret = 1'b1; step(); ack = 1'b0; ret = 1'b0;
    chk("R7 both gmask", 32'(gmask), 1);
    chk("R7 both ptr", 32'(bank_ptr), 0);
    chk("R4 nothing left", 32'(irq_valid), 0);

    // R8 pulse during own acceptance, masked hold
    do_reset();
    write_smask(4'h0);
    dev_req = 4'b0001; step();
    ack = 1'b1; step(); ack = 1'b0; dev_req = '0;
    chk("R8 masked by entry", 32'(irq_valid), 0);
    ret = 1'b1; step(); ret = 1'b0;
    chk("R8 re-request kept", 32'(irq_vector), 32'(vexp(1)));
    chk("R8 re-request valid", 32'(irq_valid), 1);
    do_reset();
    dev_req = 4'b0001; step(); dev_req = '0;
    chk("R8 masked pend hidden", 32'(irq_valid), 0);
    write_smask(4'h0);
    chk("R8 pend kept under mask", 32'(irq_vector), 32'(vexp(1)));
    // R9 hold while not acked
    step(); step();
    chk("R9 offer held", 32'(irq_valid), 1);

    // R9 idle ack
    do_reset();
    ack = 1'b1; step(); ack = 1'b0;
    chk("R9 idle ack ptr", 32'(bank_ptr), 0);
    chk("R9 idle ack gmask", 32'(gmask), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule